// File: doc/BRIEF.md
# Edge-Latched Grouped Pin Interrupt

This block watches a group of general-purpose input pins and raises one interrupt request when the group becomes active. Each pin passes through a per-pin enable. The enabled pins are combined by OR, so the group is active while any enabled pin is high. The combined level is brought into the CPU clock domain through a chain of flops. The block then takes a rising edge of the synchronised level and holds it in a latch.

The latch drives the interrupt request. A request is shown only while the CPU's global interrupt mask is clear. Servicing begins with a one-cycle acknowledge strobe, which clears the latch. Because the clear comes at the start of servicing, a new edge that arrives during the service routine is kept. It is requested again once the mask drops.

The block also drives two constant 16-bit addresses, one for the high byte and one for the low byte of the service routine vector.

Top module: `pin_edge_irq`

## Requirements
- R1: While `rst_n` is low at a clock edge, all internal state clears. After reset, `latch_bit` and `irq_req` read 0.
- R2: `vec_hi` always reads 16'h1FF6 and `vec_lo` always reads 16'h1FF7.
- R3: Suppose the combined enabled level goes from 0 to 1 in the cycle before clock edge k. Then `latch_bit` reads 1 after edge k+2 and still reads 0 after edge k+1. This holds for the default two synchroniser stages.
- R4: A pin whose `pin_en` bit is 0 never sets the latch, whatever its level does.
- R5: The latch responds to edges, not to levels. An enabled pin that stays high after an acknowledge does not set the latch again.
- R6: `irq_req` is 1 exactly when the latch is set and `gmask` is 0. A latched request held under the mask appears in the same cycle that `gmask` falls.
- R7: An `ack` sampled high at a clock edge clears the latch at that edge, unless R8 applies.
- R8: When `ack` and a detected rising edge meet at the same clock edge, the latch ends up set.
- R9: Setting the enable bit of a pin that is already high is a rising edge of the combined level. It sets the latch as in R3.
- R10: A second enabled pin going high while another enabled pin is already high causes no new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | NUM_PINS | Asynchronous pin levels |
| pin_en | input | NUM_PINS | Per-pin enable; 1 means the pin takes part in the OR |
| gmask | input | 1 | CPU global interrupt mask; 1 means requests are hidden |
| ack | input | 1 | Acknowledge strobe that clears the latch at the start of servicing |
| irq_req | output | 1 | Interrupt request to the CPU |
| latch_bit | output | 1 | Readable latched request bit |
| vec_hi | output | 16 | Address of the vector high byte |
| vec_lo | output | 16 | Address of the vector low byte |

## Verification
The main function is driven with several patterns:
- A single enabled pin rising from quiet, which fixes the three-edge latency.
- Disabled pins toggling, which shows that the mask acts before the OR.
- A second pin rising while another pin is already high, which separates an edge on the combined signal from edges on single pins.
- An enable bit set on a pin that is already high, which shows the enable is part of the edge source.

A pin held high across an acknowledge separates edge capture from level capture. An acknowledge placed in the same cycle as a detected edge settles which of the two wins. Holding a request under the mask and then releasing it shows that the request appears in the release cycle and is not lost.

// File: rtl/pei_pkg.sv
// Package: shared constants and types for the grouped pin interrupt.
// Assumes 16-bit vector addresses.
package pei_pkg;
    localparam int VEC_ADDR_W = 16;
    typedef logic [VEC_ADDR_W-1:0] vec_addr_t;
    localparam vec_addr_t VEC_HI_DEFAULT = 16'h1FF6;
    localparam vec_addr_t VEC_LO_DEFAULT = 16'h1FF7;
endpackage

// File: rtl/pei_pin_merge.sv
// Module: gates each pin by its enable and ORs the results into one level.
// Assumes the pin levels may be asynchronous; the output is purely combinational.
module pei_pin_merge #(
    parameter int NUM_PINS = 8
) (
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] pin_en,
    output logic                any_hit
);
    logic [NUM_PINS-1:0] gated;

    // Force disabled pins to 0 so they cannot produce an edge.
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_gate
        assign gated[g] = pin_lvl[g] & pin_en[g];
    end

    // Wired-OR of all enabled pins.
    always_comb begin
        any_hit = |gated;
    end
endmodule

// File: rtl/pei_sync.sv
// Module: chain of flops that carries one asynchronous level into the clock domain.
// Assumes STAGES >= 2; resets to 0 synchronously.
module pei_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;
    logic [STAGES-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the raw level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= 1'b0;
                else        chain[s] <= d;
            end
        end else begin : g_next
            // Later stages let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= 1'b0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[LAST];
endmodule

// File: rtl/pei_edge_latch.sv
// Module: finds rising edges of the synchronised level and holds them until acknowledged.
// Assumes the input is already in the clock domain. An edge wins over an acknowledge.
module pei_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_lvl,
    input  logic ack,
    output logic rise,
    output logic latch_q
);
    logic prev_lvl;

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_lvl <= 1'b0;
        else        prev_lvl <= sync_lvl;
    end

    // A rise is a low-to-high step between consecutive cycles.
    always_comb begin
        rise = sync_lvl & ~prev_lvl;
    end

    // Set on an edge, clear on acknowledge, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    latch_q <= 1'b0;
        else if (rise) latch_q <= 1'b1;
        else if (ack)  latch_q <= 1'b0;
    end
endmodule

// File: rtl/pin_edge_irq.sv
// Module: top of the grouped pin interrupt. Merges the enabled pins, synchronises
// the result, latches its rising edges and masks the request with the CPU global mask.
// Assumes ack is a one-cycle strobe from the CPU, synchronous to clk.
module pin_edge_irq
    import pei_pkg::*;
#(
    parameter int        NUM_PINS    = 8,
    parameter int        SYNC_STAGES = 2,
    parameter vec_addr_t VEC_HI      = VEC_HI_DEFAULT,
    parameter vec_addr_t VEC_LO      = VEC_LO_DEFAULT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_lvl,
    input  logic [NUM_PINS-1:0]   pin_en,
    input  logic                  gmask,
    input  logic                  ack,
    output logic                  irq_req,
    output logic                  latch_bit,
    output logic [VEC_ADDR_W-1:0] vec_hi,
    output logic [VEC_ADDR_W-1:0] vec_lo
);
    logic comb_hit;
    logic sync_hit;
    logic edge_rise;
    logic latched;

    pei_pin_merge #(.NUM_PINS(NUM_PINS)) merge_i (
        .pin_lvl (pin_lvl),
        .pin_en  (pin_en),
        .any_hit (comb_hit)
    );

    pei_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (comb_hit),
        .q     (sync_hit)
    );

    pei_edge_latch latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_lvl (sync_hit),
        .ack      (ack),
        .rise     (edge_rise),
        .latch_q  (latched)
    );

    // Present the latched request only while the mask is clear.
    always_comb begin
        irq_req   = latched & ~gmask;
        latch_bit = latched;
    end

    assign vec_hi = VEC_HI;
    assign vec_lo = VEC_LO;
endmodule

// File: rtl/pin_edge_irq_chk.sv
// Module: assertion checker for pin_edge_irq, attached with bind.
// Assumes the default two-stage synchroniser for the latency property.
module pin_edge_irq_chk (
    input logic clk,
    input logic rst_n,
    input logic gmask,
    input logic ack,
    input logic irq_req,
    input logic latch_bit,
    input logic rise,
    input logic any_hit
);
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> latch_bit); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !rise) |=> !latch_bit); // R7
    AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_bit && !rise) |=> !latch_bit); // R5
    AST_RISE_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> $past(any_hit, 2)); // R3
    AST_UNMASK_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!gmask && latch_bit) |-> irq_req); // R6
    AST_MASK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
        gmask |-> !irq_req); // R6
endmodule

bind pin_edge_irq pin_edge_irq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .gmask     (gmask),
    .ack       (ack),
    .irq_req   (irq_req),
    .latch_bit (latch_bit),
    .rise      (edge_rise),
    .any_hit   (comb_hit)
);

// File: tb/pin_edge_irq_tb_top.sv
// Bench: a behavioural reference model compared every clock, plus directed checks.
module pin_edge_irq_tb_top;
    localparam int N = 8;
    localparam int S = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_lvl = '0;
    logic [N-1:0] pin_en = '0;
    logic         gmask = 1'b0;
    logic         ack = 1'b0;
    logic         irq_req;
    logic         latch_bit;
    logic [15:0]  vec_hi;
    logic [15:0]  vec_lo;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    pin_edge_irq #(.NUM_PINS(N), .SYNC_STAGES(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_en(pin_en),
        .gmask(gmask), .ack(ack), .irq_req(irq_req), .latch_bit(latch_bit),
        .vec_hi(vec_hi), .vec_lo(vec_lo)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model: a queue of sampled group levels plus a latch flag.
    bit q[$];
    bit m_latch = 1'b0;
    always @(posedge clk) begin
        if (!rst_n) begin
            q = {};
            for (int i = 0; i <= S; i++) q.push_back(1'b0);
            m_latch = 1'b0;
        end else begin
            bit m_rise;
            m_rise  = q[S-1] && !q[S];
            m_latch = m_rise || (m_latch && !ack);
            q.push_front(|(pin_lvl & pin_en));
            void'(q.pop_back());
        end
        #3;
        if (rst_n && !done) begin
            check("R3 model latch", {15'd0, latch_bit}, {15'd0, m_latch});
            check("R6 model irq", {15'd0, irq_req}, {15'd0, m_latch && !gmask});
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #5;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1 latch after reset", {15'd0, latch_bit}, 16'd0);
        check("R1 irq after reset", {15'd0, irq_req}, 16'd0);
        check("R2 vec_hi", vec_hi, 16'h1FF6);
        check("R2 vec_lo", vec_lo, 16'h1FF7);

        // R3: single enabled pin rises.
        pin_en = 8'h01;
        pin_lvl = 8'h01;
        tick(2);
        check("R3 not yet latched", {15'd0, latch_bit}, 16'd0);
        tick(1);
        check("R3 latched", {15'd0, latch_bit}, 16'd1);
        check("R6 irq unmasked", {15'd0, irq_req}, 16'd1);

        // R7 then R5: ack clears, level held does not re-set.
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        check("R7 ack clears", {15'd0, latch_bit}, 16'd0);
        tick(5);
        check("R5 level ignored", {15'd0, latch_bit}, 16'd0);

        // R10: second pin rises while first is high.
        pin_en = 8'h09;
        pin_lvl = 8'h09;
        tick(5);
        check("R10 no second edge", {15'd0, latch_bit}, 16'd0);
        pin_lvl = 8'h00;
        tick(4);

        // R4: disabled pins toggle.
        pin_en = 8'h01;
        pin_lvl = 8'hFE;
        tick(2);
        pin_lvl = 8'h00;
        tick(2);
        pin_lvl = 8'hFE;
        tick(5);
        check("R4 disabled pins ignored", {15'd0, latch_bit}, 16'd0);

        // R9: enable a pin that is already high.
        pin_lvl = 8'h10;
        tick(4);
        pin_en = 8'h11;
        tick(2);
        check("R9 not yet latched", {15'd0, latch_bit}, 16'd0);
        tick(1);
        check("R9 enable edge latched", {15'd0, latch_bit}, 16'd1);
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        pin_lvl = 8'h00;
        tick(4);

        // R6: request held under mask, shown when the mask falls.
        gmask = 1'b1;
        pin_lvl = 8'h01;
        tick(3);
        check("R6 latched under mask", {15'd0, latch_bit}, 16'd1);
        check("R6 irq hidden", {15'd0, irq_req}, 16'd0);
        gmask = 1'b0;
        #1;
        check("R6 irq on unmask", {15'd0, irq_req}, 16'd1);

        // R8: ack and a detected edge at the same clock edge.
        pin_lvl = 8'h00;
        tick(4);
        pin_lvl = 8'h01;
        tick(2);
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        check("R8 edge wins over ack", {15'd0, latch_bit}, 16'd1);
        ack = 1'b1;
        tick(1);
        ack = 1'b0;
        check("R7 second ack clears", {15'd0, latch_bit}, 16'd0);
        tick(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule